// File: doc/BRIEF.md
# Address-Space-Tagged Fully Associative Translation Buffer

This block caches virtual-to-physical page translations for one requester. Every slot keeps a virtual page number (VPN) tag, a physical page number (PPN), an address-space number (ASN), a global flag, a read-permission mask and a write-permission mask with one bit per privilege mode, and two fault-on-access flags, one for reads and one for writes. A lookup is purely combinational. It compares the presented VPN and ASN against every slot and returns the hit, the PPN and the attributes in the same cycle.

Software-managed refill goes through a fill port. The fill port always writes the slot chosen by a rotating victim pointer, whether that slot is in use or not. Three invalidation commands keep the buffer coherent across context switches and unmaps. One empties the whole buffer. One drops every slot not marked global. One drops every slot that would hit for a given VPN and ASN. Fills and flushes take effect at the next rising clock edge.

Top module: `tag_xlat_buf`

## Requirements
- R1: A slot hits only when it is valid, its tag equals `lk_vpn`, and either its global flag is set or its stored ASN equals `lk_asn`.
- R2: When a fill is accepted, the pointed slot receives tag `ins_vaddr[VA_W-1:PAGE_SHIFT]` (the bits above the page offset), together with the PPN, ASN, global flag, both masks and both fault flags, and the slot becomes valid. A later hit returns exactly these fields.
- R3: The victim pointer advances by one on each accepted fill and wraps from the last slot to slot 0. The fill overwrites the pointed slot even if it is valid, so with 16 slots the 17th fill after reset replaces the first.
- R4: `flush_all` clears every valid flag and returns the victim pointer to slot 0.
- R5: `flush_nonglobal` invalidates every slot whose global flag is clear and keeps every global slot.
- R6: `flush_addr_en` invalidates every slot that would hit, under R1, for `flush_vpn` and `flush_asn`. This includes global slots with that tag.
- R7: Commands that arrive in the same cycle are ranked as follows: flush-all first, then fill, then the two selective flushes. A command that loses is dropped entirely. A fill that loses to flush-all does not move the pointer off slot 0.
- R8: When no flush-all and no fill is present, a non-global flush and an address flush in the same cycle are both applied.
- R9: The lookup outputs depend only on the current contents and the lookup inputs. A fill or flush that is present before an edge is not seen by lookups until after that edge.
- R10: When several slots hit, the outputs come from the lowest-numbered hitting slot.
- R11: On a miss, `lk_hit`, `lk_ppn`, both masks, both fault flags and `lk_global` are all zero.
- R12: After reset every slot is invalid and the victim pointer is at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asn | input | ASN_W | Lookup address-space number |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PPN_W | Physical page number of the hit |
| lk_rd_mask | output | MODES | Read-enable mask, one bit per mode |
| lk_wr_mask | output | MODES | Write-enable mask, one bit per mode |
| lk_fault_rd | output | 1 | Fault-on-read flag of the hit |
| lk_fault_wr | output | 1 | Fault-on-write flag of the hit |
| lk_global | output | 1 | Global flag of the hit |
| ins_en | input | 1 | Fill request |
| ins_vaddr | input | VA_W | Virtual address whose page is filled |
| ins_ppn | input | PPN_W | PPN to store |
| ins_asn | input | ASN_W | ASN to store |
| ins_global | input | 1 | Global flag to store |
| ins_rd_mask | input | MODES | Read mask to store |
| ins_wr_mask | input | MODES | Write mask to store |
| ins_fault_rd | input | 1 | Fault-on-read flag to store |
| ins_fault_wr | input | 1 | Fault-on-write flag to store |
| flush_all | input | 1 | Invalidate everything, pointer to 0 |
| flush_nonglobal | input | 1 | Invalidate all non-global slots |
| flush_addr_en | input | 1 | Invalidate slots hitting flush_vpn/flush_asn |
| flush_vpn | input | VPN_W | Page for the address flush |
| flush_asn | input | ASN_W | ASN for the address flush |

## Verification
A lookup result is due in the same cycle as its inputs. A fill or flush shows in lookups only after the next rising edge. The bench therefore drives commands after a falling edge and lets one rising edge pass. It then withdraws the commands, and at the following falling edge it presents several lookups, comparing each a fraction of a nanosecond later against a reference model that was updated for that edge. One directed case probes lookups while a fill is still pending before the edge, and expects the old contents there.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   // Command resolved for one cycle, after ranking simultaneous requests.
   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_WIPE  = 2'd1,
      OP_FILL  = 2'd2,
      OP_PRUNE = 2'd3
   } tlb_op_e;

   // Ranking: wipe beats fill, fill beats the selective flushes.
   function automatic tlb_op_e rank_op(input logic wipe,
                                       input logic fill,
                                       input logic prune);
      if (wipe)
         return OP_WIPE;
      else if (fill)
         return OP_FILL;
      else if (prune)
         return OP_PRUNE;
      else
         return OP_NONE;
   endfunction

endpackage

// File: rtl/tlb_slot.sv
module tlb_slot #(
   parameter int VPN_W = 19,
   parameter int PPN_W = 20,
   parameter int ASN_W = 8,
   parameter int MODES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             kill,
   input  logic [VPN_W-1:0] d_vpn,
   input  logic [PPN_W-1:0] d_ppn,
   input  logic [ASN_W-1:0] d_asn,
   input  logic             d_glb,
   input  logic [MODES-1:0] d_rd,
   input  logic [MODES-1:0] d_wr,
   input  logic             d_frd,
   input  logic             d_fwr,
   input  logic [VPN_W-1:0] q_vpn,
   input  logic [ASN_W-1:0] q_asn,
   input  logic [VPN_W-1:0] f_vpn,
   input  logic [ASN_W-1:0] f_asn,
   output logic             o_valid,
   output logic             o_glb,
   output logic             o_hit,
   output logic             o_fmatch,
   output logic [PPN_W-1:0] o_ppn,
   output logic [MODES-1:0] o_rd,
   output logic [MODES-1:0] o_wr,
   output logic             o_frd,
   output logic             o_fwr
);

   logic             vld_q;
   logic [VPN_W-1:0] tag_q;
   logic [ASN_W-1:0] asn_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         vld_q <= 1'b0;
      else if (load)
         vld_q <= 1'b1;
      else if (kill)
         vld_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_q <= '0;
         asn_q <= '0;
         o_ppn <= '0;
         o_glb <= 1'b0;
         o_rd  <= '0;
         o_wr  <= '0;
         o_frd <= 1'b0;
         o_fwr <= 1'b0;
      end else if (load) begin
         tag_q <= d_vpn;
         asn_q <= d_asn;
         o_ppn <= d_ppn;
         o_glb <= d_glb;
         o_rd  <= d_rd;
         o_wr  <= d_wr;
         o_frd <= d_frd;
         o_fwr <= d_fwr;
      end
   end

   assign o_valid  = vld_q;
   assign o_hit    = vld_q && (tag_q == q_vpn) && (o_glb || (asn_q == q_asn));
   assign o_fmatch = vld_q && (tag_q == f_vpn) && (o_glb || (asn_q == f_asn));

   // R2: a load leaves the slot valid after the edge
   a_r2_load_sets_valid : assert property (@(posedge clk) disable iff (!rst_n)
      load |=> o_valid);

   // R2: loaded tag is what later matches
   a_r2_load_tag : assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (tag_q == $past(d_vpn)));

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
   parameter int N = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 adv,
   input  logic                 home,
   output logic [$clog2(N)-1:0] ptr
);

   localparam int IW   = $clog2(N);
   localparam int LAST = N - 1;

   logic [IW-1:0] nxt;

   generate
      if (N == (1 << IW)) begin : g_pow2
         assign nxt = ptr + IW'(1);
      end else begin : g_cmp
         assign nxt = (ptr == IW'(LAST)) ? '0 : ptr + IW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr <= '0;
      else if (home)
         ptr <= '0;
      else if (adv)
         ptr <= nxt;
   end

   // R3: advance by one, wrapping at the last slot
   a_r3_ptr_step : assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !home) |=> (ptr == (($past(ptr) == IW'(LAST)) ? '0 : $past(ptr) + IW'(1))));

   // R4: a wipe sends the pointer home
   a_r4_ptr_home : assert property (@(posedge clk) disable iff (!rst_n)
      home |=> (ptr == '0));

   a_r3_ptr_range : assert property (@(posedge clk) disable iff (!rst_n)
      32'(ptr) <= LAST);

endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
   parameter int N = 16,
   parameter int W = 31
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   hits,
   input  logic [N*W-1:0] data,
   output logic           any,
   output logic [W-1:0]   sel
);

   logic [N-1:0] first;

   // isolate lowest set bit: lowest index wins
   assign first = hits & (~hits + N'(1));
   assign any   = |hits;

   always_comb begin
      sel = '0;
      for (int i = 0; i < N; i++) begin
         sel = sel | ({W{first[i]}} & data[i*W +: W]);
      end
   end

   // R10: at most one slot drives the output
   a_r10_one_winner : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(first));

   // R11: no winner means an all-zero payload
   a_r11_miss_zero : assert property (@(posedge clk) disable iff (!rst_n)
      !any |-> (sel == '0));

endmodule

// File: rtl/tag_xlat_buf.sv
module tag_xlat_buf #(
   parameter int ENTRIES    = 16,
   parameter int VPN_W      = 19,
   parameter int PAGE_SHIFT = 13,
   parameter int PPN_W      = 20,
   parameter int ASN_W      = 8,
   parameter int MODES      = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [VPN_W-1:0]            lk_vpn,
   input  logic [ASN_W-1:0]            lk_asn,
   output logic                        lk_hit,
   output logic [PPN_W-1:0]            lk_ppn,
   output logic [MODES-1:0]            lk_rd_mask,
   output logic [MODES-1:0]            lk_wr_mask,
   output logic                        lk_fault_rd,
   output logic                        lk_fault_wr,
   output logic                        lk_global,
   input  logic                        ins_en,
   input  logic [VPN_W+PAGE_SHIFT-1:0] ins_vaddr,
   input  logic [PPN_W-1:0]            ins_ppn,
   input  logic [ASN_W-1:0]            ins_asn,
   input  logic                        ins_global,
   input  logic [MODES-1:0]            ins_rd_mask,
   input  logic [MODES-1:0]            ins_wr_mask,
   input  logic                        ins_fault_rd,
   input  logic                        ins_fault_wr,
   input  logic                        flush_all,
   input  logic                        flush_nonglobal,
   input  logic                        flush_addr_en,
   input  logic [VPN_W-1:0]            flush_vpn,
   input  logic [ASN_W-1:0]            flush_asn
);
   import tlb_pkg::*;

   localparam int VA_W = VPN_W + PAGE_SHIFT;
   localparam int IW   = $clog2(ENTRIES);
   localparam int PW   = PPN_W + 2*MODES + 3;

   generate
      if (ENTRIES < 2) begin : g_bad_entries
         $error("tag_xlat_buf: ENTRIES must be at least 2");
      end
      if (VPN_W < 1 || PPN_W < 1 || ASN_W < 1 || MODES < 1) begin : g_bad_width
         $error("tag_xlat_buf: widths must be positive");
      end
   endgenerate

   tlb_op_e         op;
   logic [IW-1:0]   ptr;
   logic [VPN_W-1:0] ins_vpn;
   logic [ENTRIES-1:0] valid_vec, glb_vec, hit_vec, fm_vec, load_vec, kill_vec;
   logic [ENTRIES*PW-1:0] pay_flat;
   logic [PW-1:0]   pay_sel;

   assign op      = rank_op(flush_all, ins_en, flush_nonglobal | flush_addr_en);
   assign ins_vpn = ins_vaddr[VA_W-1:PAGE_SHIFT];

   tlb_victim #(.N(ENTRIES)) u_victim (
      .clk  (clk),
      .rst_n(rst_n),
      .adv  (op == OP_FILL),
      .home (op == OP_WIPE),
      .ptr  (ptr)
   );

   generate
      for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
         logic [PPN_W-1:0] s_ppn;
         logic [MODES-1:0] s_rd, s_wr;
         logic             s_frd, s_fwr;

         assign load_vec[i] = (op == OP_FILL) && (ptr == IW'(i));
         assign kill_vec[i] = (op == OP_WIPE) ||
                              ((op == OP_PRUNE) &&
                               ((flush_nonglobal && !glb_vec[i]) ||
                                (flush_addr_en && fm_vec[i])));

         tlb_slot #(
            .VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W), .MODES(MODES)
         ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load_vec[i]),
            .kill    (kill_vec[i]),
            .d_vpn   (ins_vpn),
            .d_ppn   (ins_ppn),
            .d_asn   (ins_asn),
            .d_glb   (ins_global),
            .d_rd    (ins_rd_mask),
            .d_wr    (ins_wr_mask),
            .d_frd   (ins_fault_rd),
            .d_fwr   (ins_fault_wr),
            .q_vpn   (lk_vpn),
            .q_asn   (lk_asn),
            .f_vpn   (flush_vpn),
            .f_asn   (flush_asn),
            .o_valid (valid_vec[i]),
            .o_glb   (glb_vec[i]),
            .o_hit   (hit_vec[i]),
            .o_fmatch(fm_vec[i]),
            .o_ppn   (s_ppn),
            .o_rd    (s_rd),
            .o_wr    (s_wr),
            .o_frd   (s_frd),
            .o_fwr   (s_fwr)
         );

         assign pay_flat[i*PW +: PW] = {s_ppn, s_rd, s_wr, s_frd, s_fwr, glb_vec[i]};
      end
   endgenerate

   tlb_pick #(.N(ENTRIES), .W(PW)) u_pick (
      .clk  (clk),
      .rst_n(rst_n),
      .hits (hit_vec),
      .data (pay_flat),
      .any  (lk_hit),
      .sel  (pay_sel)
   );

   assign {lk_ppn, lk_rd_mask, lk_wr_mask, lk_fault_rd, lk_fault_wr, lk_global} = pay_sel;

   // R4: wipe empties the buffer
   a_r4_wipe_all : assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> (valid_vec == '0));

   // R5: non-global flush leaves only global slots
   a_r5_keep_global : assert property (@(posedge clk) disable iff (!rst_n)
      (flush_nonglobal && !flush_all && !ins_en) |=> ((valid_vec & ~glb_vec) == '0));

   // R5: global slots survive a non-global-only flush
   a_r5_global_stays : assert property (@(posedge clk) disable iff (!rst_n)
      (flush_nonglobal && !flush_addr_en && !flush_all && !ins_en)
         |=> (valid_vec == ($past(valid_vec) & $past(glb_vec))));

   // R7: a fill beating a flush lands in the pointed slot
   a_r7_fill_wins : assert property (@(posedge clk) disable iff (!rst_n)
      (ins_en && !flush_all) |=> valid_vec[$past(ptr)]);

   // R1: a reported hit implies some slot matched
   a_r1_hit_source : assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (hit_vec != '0) && ((hit_vec & ~valid_vec) == '0));

endmodule

// File: tb/sim_tag_xlat_buf.sv
`timescale 1ns/1ps
module sim_tag_xlat_buf;
   localparam int N   = 16;
   localparam int VW  = 19;
   localparam int PS  = 13;
   localparam int PW  = 20;
   localparam int AW  = 8;
   localparam int MD  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [VW-1:0] lk_vpn = '0;
   logic [AW-1:0] lk_asn = '0;
   logic lk_hit, lk_fault_rd, lk_fault_wr, lk_global;
   logic [PW-1:0] lk_ppn;
   logic [MD-1:0] lk_rd_mask, lk_wr_mask;
   logic ins_en = 0, ins_global = 0, ins_fault_rd = 0, ins_fault_wr = 0;
   logic [VW+PS-1:0] ins_vaddr = '0;
   logic [PW-1:0] ins_ppn = '0;
   logic [AW-1:0] ins_asn = '0;
   logic [MD-1:0] ins_rd_mask = '0, ins_wr_mask = '0;
   logic flush_all = 0, flush_nonglobal = 0, flush_addr_en = 0;
   logic [VW-1:0] flush_vpn = '0;
   logic [AW-1:0] flush_asn = '0;

   tag_xlat_buf u0 (.*);

   // reference model
   bit            m_v [N];
   logic [VW-1:0] m_tag [N];
   logic [PW-1:0] m_ppn [N];
   logic [AW-1:0] m_asn [N];
   bit            m_g [N];
   logic [MD-1:0] m_rd [N], m_wr [N];
   bit            m_fr [N], m_fw [N];
   int            m_ptr;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   function automatic int ref_find(logic [VW-1:0] v, logic [AW-1:0] a);
      for (int i = 0; i < N; i++)
         if (m_v[i] && m_tag[i] == v && (m_g[i] || m_asn[i] == a)) return i;
      return -1;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < N; i++) m_v[i] = 0;
      m_ptr = 0;
   endtask

   task automatic model_apply();
      if (flush_all) begin
         model_reset();
      end else if (ins_en) begin
         m_v[m_ptr] = 1; m_tag[m_ptr] = ins_vaddr[VW+PS-1:PS];
         m_ppn[m_ptr] = ins_ppn; m_asn[m_ptr] = ins_asn; m_g[m_ptr] = ins_global;
         m_rd[m_ptr] = ins_rd_mask; m_wr[m_ptr] = ins_wr_mask;
         m_fr[m_ptr] = ins_fault_rd; m_fw[m_ptr] = ins_fault_wr;
         m_ptr = (m_ptr + 1) % N;
      end else begin
         for (int i = 0; i < N; i++)
            if (m_v[i] && ((flush_nonglobal && !m_g[i]) ||
                (flush_addr_en && m_tag[i] == flush_vpn && (m_g[i] || m_asn[i] == flush_asn))))
               m_v[i] = 0;
      end
   endtask

   task automatic check(logic [VW-1:0] v, logic [AW-1:0] a, string req);
      int k;
      logic [PW+2*MD+4-1:0] exp_w, act_w;
      lk_vpn = v; lk_asn = a;
      #0.2;
      k = ref_find(v, a);
      if (k < 0) exp_w = '0;
      else exp_w = {1'b1, m_ppn[k], m_rd[k], m_wr[k], m_fr[k], m_fw[k], m_g[k]};
      act_w = {lk_hit, lk_ppn, lk_rd_mask, lk_wr_mask, lk_fault_rd, lk_fault_wr, lk_global};
      n_chk++;
      if (act_w !== exp_w) begin
         n_bad++;
         $display("FAIL %s vpn=%0h asn=%0h actual=%h expected=%h", req, v, a, act_w, exp_w);
      end
   endtask

   task automatic clear_cmds();
      ins_en = 0; flush_all = 0; flush_nonglobal = 0; flush_addr_en = 0;
   endtask

   // apply currently driven commands over one edge, then withdraw them
   task automatic edge_apply();
      @(posedge clk);
      #0.1;
      model_apply();
      @(negedge clk);
      clear_cmds();
   endtask

   task automatic do_fill(int v, int a, bit g, int p);
      @(negedge clk);
      ins_en = 1; ins_vaddr = {VW'(v), PS'($urandom)}; ins_asn = AW'(a);
      ins_global = g; ins_ppn = PW'(p);
      ins_rd_mask = MD'($urandom); ins_wr_mask = MD'($urandom);
      ins_fault_rd = 1'($urandom); ins_fault_wr = 1'($urandom);
      edge_apply();
   endtask

   initial begin
      #(200000 * 5.0);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      // R12 R11: empty after reset, zero outputs on miss
      for (int i = 0; i < 4; i++) check(VW'(i), AW'(i), "R12 R11 reset");

      // R2: fill all slots and read back
      for (int i = 0; i < N; i++) do_fill(i, 1, 0, 'h100 + i);
      for (int i = 0; i < N; i++) check(VW'(i), AW'(1), "R2 fill readback");
      check(VW'(3), AW'(2), "R1 asn mismatch");
      // R3: 17th fill evicts slot 0
      do_fill(100, 1, 0, 'h777);
      check(VW'(0), AW'(1), "R3 wrap evict");
      check(VW'(100), AW'(1), "R3 wrap fill");
      // R10: duplicate vpn 5 into slot 1, lowest index wins
      do_fill(5, 1, 0, 'h555);
      check(VW'(5), AW'(1), "R10 lowest index");
      // R1: global slot hits any asn
      do_fill(40, 9, 1, 'h404);
      check(VW'(40), AW'(3), "R1 global any asn");
      // R6: address flush with wrong asn keeps non-global, right asn drops
      @(negedge clk); flush_addr_en = 1; flush_vpn = 7; flush_asn = 2; edge_apply();
      check(VW'(7), AW'(1), "R6 wrong asn kept");
      @(negedge clk); flush_addr_en = 1; flush_vpn = 7; flush_asn = 1; edge_apply();
      check(VW'(7), AW'(1), "R6 match dropped");
      @(negedge clk); flush_addr_en = 1; flush_vpn = 40; flush_asn = 0; edge_apply();
      check(VW'(40), AW'(9), "R6 global dropped");
      do_fill(41, 9, 1, 'h414);
      // R7: fill beats non-global flush
      @(negedge clk); ins_en = 1; ins_vaddr = {VW'(50), PS'(0)}; ins_asn = 2; ins_global = 0;
      flush_nonglobal = 1;
      // R9: not visible before the edge
      check(VW'(50), AW'(2), "R9 pre-edge");
      edge_apply();
      check(VW'(50), AW'(2), "R7 fill wins");
      check(VW'(8), AW'(1), "R7 flush dropped");
      // R8 R5: both selective flushes together
      @(negedge clk); flush_nonglobal = 1; flush_addr_en = 1; flush_vpn = 41; flush_asn = 9; edge_apply();
      check(VW'(41), AW'(9), "R8 addr part");
      check(VW'(8), AW'(1), "R8 R5 nonglobal part");
      do_fill(42, 0, 1, 'h424);
      @(negedge clk); flush_nonglobal = 1; edge_apply();
      check(VW'(42), AW'(5), "R5 global kept");
      // R7 R4: flush_all beats fill, pointer home
      @(negedge clk); flush_all = 1; ins_en = 1; ins_vaddr = {VW'(60), PS'(0)}; edge_apply();
      check(VW'(60), AW'(0), "R7 R4 fill dropped");
      check(VW'(42), AW'(5), "R4 cleared");
      for (int i = 0; i < N + 1; i++) do_fill(200 + i, 0, 0, i);
      check(VW'(200), AW'(0), "R4 pointer home");
      check(VW'(216), AW'(0), "R3 after home");

      // random phase
      for (int s = 0; s < 3000; s++) begin
         int r;
         @(negedge clk);
         r = $urandom_range(0, 99);
         flush_all = (r < 2);
         ins_en = ($urandom_range(0, 99) < 45);
         flush_nonglobal = ($urandom_range(0, 99) < 5);
         flush_addr_en = ($urandom_range(0, 99) < 20);
         ins_vaddr = {VW'($urandom_range(0, 23)), PS'($urandom)};
         ins_asn = AW'($urandom_range(0, 3)); ins_global = ($urandom_range(0, 3) == 0);
         ins_ppn = PW'($urandom); ins_rd_mask = MD'($urandom); ins_wr_mask = MD'($urandom);
         ins_fault_rd = 1'($urandom); ins_fault_wr = 1'($urandom);
         flush_vpn = VW'($urandom_range(0, 23)); flush_asn = AW'($urandom_range(0, 3));
         edge_apply();
         for (int q = 0; q < 3; q++) begin
            int k = $urandom_range(0, N - 1);
            if (q == 0 && m_v[k]) check(m_tag[k], $urandom_range(0, 3), "R1 R2 R6 random");
            else check(VW'($urandom_range(0, 23)), AW'($urandom_range(0, 3)), "R1 R3 R5 R7 R10 random");
         end
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule